// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Unit

This block is the multiply-accumulate datapath of a 16-bit fixed-point signal processor. It holds a 40-bit product register and two 40-bit accumulators. When the strobe is high, each clock edge performs one operation. Three operations affect only the product register: multiply, multiply-add and multiply-subtract. Three others first move the previous product into a chosen accumulator, then load the new operand product. The move can be a plain copy, a round-then-copy, or an add into the accumulator.

The product register acts as a one-deep pipeline stage. An accumulator-writing operation therefore always consumes the product left by the instruction before it. The multiplier has no flags. Status flags change only on the three accumulator-writing operations, and each of those has its own carry and overflow rule. Operand fetch and instruction decode sit outside this block.

Top module: `dsp_mac_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the product register, both accumulators and all six flags to zero.
- R2: When `valid` is low, or `opcode` is 6 or 7, the edge changes neither the product register, the accumulators nor the flags.
- R3: Opcode 0 (multiply) loads the product register with the signed 16x16 product of `op_a` and `op_b`, sign-extended to 40 bits. The accumulators stay unchanged.
- R4: Opcode 1 (multiply-add) loads the product register with the old 40-bit product plus the new signed operand product, modulo 2^40.
- R5: Opcode 2 (multiply-subtract) loads the product register with the old 40-bit product minus the new signed operand product, modulo 2^40.
- R6: Opcode 3 (move-and-multiply) copies the old product into the selected accumulator, loads the new operand product, and clears carry and overflow.
- R7: Opcode 4 (round-and-multiply) adds a rounding term to the old product, clears bits 15..0 of the sum, writes the result to the selected accumulator and loads the new operand product. The rounding term is 0x8000, except when the old product's bits 15..0 equal exactly 0x8000.
- R8: In the exact-half case of R7, the rounding term is 0x8000 when old product bit 16 is 1 and 0 when it is 0, which rounds half to even.
- R9: Opcode 5 (add-and-multiply) writes the 40-bit sum of the selected accumulator and the old product to that accumulator, then loads the new operand product.
- R10: For opcodes 4 and 5, carry is the carry out of bit 39 of the 40-bit addition of old product and addend. Overflow is set when both addends have the same bit 39 and the sum's bit 39 differs from it.
- R11: For opcodes 3 to 5, zero flags an all-zero written value and negative copies its bit 39. Extension is set when bits 39..31 are not all equal. Unnormalized is set when bit 31 equals bit 30.
- R12: `acc_sel` 0 selects accumulator A and 1 selects B. The accumulator that is not selected is never written.
- R13: Opcodes 0 to 2 leave all six flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | Perform the operation on this edge |
| opcode | input | 3 | Operation code, 0 to 5; 6 and 7 do nothing |
| op_a | input | 16 | First signed operand |
| op_b | input | 16 | Second signed operand |
| acc_sel | input | 1 | Target accumulator: 0 = A, 1 = B |
| prod | output | 40 | Product register |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| flag_c | output | 1 | Carry |
| flag_v | output | 1 | Overflow |
| flag_z | output | 1 | Zero |
| flag_n | output | 1 | Negative |
| flag_e | output | 1 | Extension |
| flag_u | output | 1 | Unnormalized |

## Verification
Every result is registered. The product register, the chosen accumulator and the flags all show the effect of a strobed operation just after the very edge that accepts it, which is one cycle of latency. A product loaded at edge k becomes the operand of an accumulator-writing operation accepted at edge k+1. The bench drives inputs on the falling edge and compares every output against its own arithmetic model shortly after the following rising edge, before it drives the next operation. The pipelined product is therefore checked in the same cycle that it is consumed.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int MAC_DW = 16;
  localparam int MAC_AW = 40;
  localparam int MAC_RW = 16;
  localparam int MAC_NACC = 2;

  typedef enum logic [2:0] {
    OP_MUL    = 3'd0,
    OP_MULADD = 3'd1,
    OP_MULSUB = 3'd2,
    OP_MOVMUL = 3'd3,
    OP_RNDMUL = 3'd4,
    OP_ADDMUL = 3'd5,
    OP_NOP6   = 3'd6,
    OP_NOP7   = 3'd7
  } mac_op_e;

  typedef struct packed {
    logic c;
    logic v;
    logic z;
    logic n;
    logic e;
    logic u;
  } mac_flags_t;

  function automatic logic op_writes_acc(input logic [2:0] op);
    return (op == OP_MOVMUL) || (op == OP_RNDMUL) || (op == OP_ADDMUL);
  endfunction

  function automatic logic op_prod_only(input logic [2:0] op);
    return (op == OP_MUL) || (op == OP_MULADD) || (op == OP_MULSUB);
  endfunction
endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int DW = mac_pkg::MAC_DW,
  parameter int AW = mac_pkg::MAC_AW
) (
  input  logic [2:0]    opcode,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic [AW-1:0] prod_q,
  output logic [AW-1:0] mul_ext,
  output logic [AW-1:0] prod_next
);
  localparam int PW = 2 * DW;

  function automatic logic [AW-1:0] signed_product(input logic [DW-1:0] a,
                                                   input logic [DW-1:0] b);
    logic signed [PW-1:0] p;
    p = $signed(a) * $signed(b);
    return {{(AW-PW){p[PW-1]}}, p};
  endfunction

  always_comb begin
    mul_ext = signed_product(op_a, op_b);
    unique case (opcode)
      mac_pkg::OP_MULADD: prod_next = prod_q + mul_ext;
      mac_pkg::OP_MULSUB: prod_next = prod_q - mul_ext;
      default:            prod_next = mul_ext;
    endcase
  end
endmodule

// File: rtl/mac_acc_alu.sv
module mac_acc_alu #(
  parameter int AW = mac_pkg::MAC_AW,
  parameter int RW = mac_pkg::MAC_RW
) (
  input  logic [2:0]    opcode,
  input  logic [AW-1:0] prod_q,
  input  logic [AW-1:0] acc_src,
  output logic [AW-1:0] rnd_term,
  output logic [AW-1:0] result,
  output logic          carry,
  output logic          ovf
);
  localparam logic [AW-1:0] HALF = AW'(1) << (RW - 1);
  localparam logic [AW-1:0] LOW_MASK = (AW'(1) << RW) - AW'(1);

  function automatic logic [AW-1:0] round_term(input logic [AW-1:0] p);
    if (p[RW-1:0] == HALF[RW-1:0])
      return p[RW] ? HALF : '0;
    return HALF;
  endfunction

  logic [AW-1:0] addend;
  logic [AW:0]   sum;

  always_comb begin
    rnd_term = round_term(prod_q);
    unique case (opcode)
      mac_pkg::OP_RNDMUL: addend = rnd_term;
      mac_pkg::OP_ADDMUL: addend = acc_src;
      default:            addend = '0;
    endcase
    sum   = {1'b0, prod_q} + {1'b0, addend};
    carry = (opcode != mac_pkg::OP_MOVMUL) && sum[AW];
    ovf   = (opcode != mac_pkg::OP_MOVMUL) &&
            (prod_q[AW-1] == addend[AW-1]) && (sum[AW-1] != prod_q[AW-1]);
    result = (opcode == mac_pkg::OP_RNDMUL) ? (sum[AW-1:0] & ~LOW_MASK)
                                            : sum[AW-1:0];
  end
endmodule

// File: rtl/mac_flag_gen.sv
module mac_flag_gen #(
  parameter int AW = mac_pkg::MAC_AW,
  parameter int GUARD = 9
) (
  input  logic [AW-1:0] value,
  output logic          zero,
  output logic          neg,
  output logic          ext,
  output logic          unnorm
);
  localparam int HI_LSB = AW - GUARD;

  always_comb begin
    zero   = (value == '0);
    neg    = value[AW-1];
    ext    = !((value[AW-1:HI_LSB] == '0) || (value[AW-1:HI_LSB] == '1));
    unnorm = (value[HI_LSB] == value[HI_LSB-1]);
  end
endmodule

// File: rtl/dsp_mac_unit.sv
module dsp_mac_unit #(
  parameter int DW = mac_pkg::MAC_DW,
  parameter int AW = mac_pkg::MAC_AW,
  parameter int RW = mac_pkg::MAC_RW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid,
  input  logic [2:0]    opcode,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic          acc_sel,
  output logic [AW-1:0] prod,
  output logic [AW-1:0] acc_a,
  output logic [AW-1:0] acc_b,
  output logic          flag_c,
  output logic          flag_v,
  output logic          flag_z,
  output logic          flag_n,
  output logic          flag_e,
  output logic          flag_u
);
  import mac_pkg::*;

  localparam int NACC = MAC_NACC;

  logic [AW-1:0]            prod_q;
  logic [AW-1:0]            mul_ext;
  logic [AW-1:0]            prod_next;
  logic [NACC-1:0][AW-1:0]  acc_all;
  logic [AW-1:0]            acc_src;
  logic [AW-1:0]            rnd_term;
  logic [AW-1:0]            alu_res;
  logic                     alu_c;
  logic                     alu_v;
  logic                     res_z, res_n, res_e, res_u;
  mac_flags_t               flags_q;

  // Named events for the checker
  logic prod_wr;
  logic acc_wr;
  logic flag_wr;

  assign prod_wr = valid && (op_prod_only(opcode) || op_writes_acc(opcode));
  assign acc_wr  = valid && op_writes_acc(opcode);
  assign flag_wr = acc_wr;
  assign acc_src = acc_all[acc_sel];

  mac_mult #(.DW(DW), .AW(AW)) u_mult (
    .opcode   (opcode),
    .op_a     (op_a),
    .op_b     (op_b),
    .prod_q   (prod_q),
    .mul_ext  (mul_ext),
    .prod_next(prod_next)
  );

  mac_acc_alu #(.AW(AW), .RW(RW)) u_alu (
    .opcode  (opcode),
    .prod_q  (prod_q),
    .acc_src (acc_src),
    .rnd_term(rnd_term),
    .result  (alu_res),
    .carry   (alu_c),
    .ovf     (alu_v)
  );

  mac_flag_gen #(.AW(AW)) u_flags (
    .value (alu_res),
    .zero  (res_z),
    .neg   (res_n),
    .ext   (res_e),
    .unnorm(res_u)
  );

  always_ff @(posedge clk) begin
    if (rst)
      prod_q <= '0;
    else if (prod_wr)
      prod_q <= prod_next;
  end

  for (genvar k = 0; k < NACC; k++) begin : g_acc
    logic [AW-1:0] acc_q;
    always_ff @(posedge clk) begin
      if (rst)
        acc_q <= '0;
      else if (acc_wr && (acc_sel == 1'(k)))
        acc_q <= alu_res;
    end
    assign acc_all[k] = acc_q;
  end

  always_ff @(posedge clk) begin
    if (rst)
      flags_q <= '0;
    else if (flag_wr)
      flags_q <= '{c: alu_c, v: alu_v, z: res_z, n: res_n, e: res_e, u: res_u};
  end

  assign prod   = prod_q;
  assign acc_a  = acc_all[0];
  assign acc_b  = acc_all[1];
  assign flag_c = flags_q.c;
  assign flag_v = flags_q.v;
  assign flag_z = flags_q.z;
  assign flag_n = flags_q.n;
  assign flag_e = flags_q.e;
  assign flag_u = flags_q.u;
endmodule

// File: rtl/mac_unit_checker.sv
module mac_unit_checker #(
  parameter int AW = mac_pkg::MAC_AW
) (
  input logic          clk,
  input logic          rst,
  input logic          valid,
  input logic [2:0]    opcode,
  input logic          acc_sel,
  input logic [AW-1:0] prod,
  input logic [AW-1:0] acc_a,
  input logic [AW-1:0] acc_b,
  input logic          flag_c,
  input logic          flag_v,
  input logic          flag_z,
  input logic          flag_n,
  input logic          flag_e,
  input logic          flag_u,
  input logic          acc_wr,
  input logic          flag_wr
);
  logic [5:0] flag_vec;
  assign flag_vec = {flag_c, flag_v, flag_z, flag_n, flag_e, flag_u};

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (prod == '0) && (acc_a == '0) && (acc_b == '0) && (flag_vec == '0));

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!valid || opcode >= 3'd6) |=> $stable(prod) && $stable(acc_a) &&
                                   $stable(acc_b) && $stable(flag_vec));

  a_r6_move_copies: assert property (@(posedge clk) disable iff (rst)
    (valid && opcode == 3'd3 && !acc_sel) |=> (acc_a == $past(prod)));

  a_r6_move_clears_cv: assert property (@(posedge clk) disable iff (rst)
    (valid && opcode == 3'd3) |=> (!flag_c && !flag_v));

  a_r7_low_cleared: assert property (@(posedge clk) disable iff (rst)
    (valid && opcode == 3'd4) |=>
      ($past(acc_sel) ? (acc_b[15:0] == 16'h0) : (acc_a[15:0] == 16'h0)));

  a_r11_neg_tracks: assert property (@(posedge clk) disable iff (rst)
    flag_wr |=> (flag_n == ($past(acc_sel) ? acc_b[AW-1] : acc_a[AW-1])));

  a_r11_zero_tracks: assert property (@(posedge clk) disable iff (rst)
    flag_wr |=> (flag_z == ($past(acc_sel) ? (acc_b == '0) : (acc_a == '0))));

  a_r12_other_acc_a: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && acc_sel) |=> $stable(acc_a));

  a_r12_other_acc_b: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && !acc_sel) |=> $stable(acc_b));

  a_r13_flags_hold: assert property (@(posedge clk) disable iff (rst)
    (valid && opcode <= 3'd2) |=> $stable(flag_vec));
endmodule

bind dsp_mac_unit mac_unit_checker #(.AW(AW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .valid  (valid),
  .opcode (opcode),
  .acc_sel(acc_sel),
  .prod   (prod),
  .acc_a  (acc_a),
  .acc_b  (acc_b),
  .flag_c (flag_c),
  .flag_v (flag_v),
  .flag_z (flag_z),
  .flag_n (flag_n),
  .flag_e (flag_e),
  .flag_u (flag_u),
  .acc_wr (acc_wr),
  .flag_wr(flag_wr)
);

// File: tb/tb_dsp_mac_unit.sv
module tb_dsp_mac_unit;
  localparam int CLK_PERIOD = 10;
  localparam longint M40 = 64'h0000_00FF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid = 1'b0;
  logic [2:0]  opcode = '0;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic        acc_sel = 1'b0;
  logic [39:0] prod, acc_a, acc_b;
  logic        flag_c, flag_v, flag_z, flag_n, flag_e, flag_u;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  longint m_prod;
  longint m_acc [2];
  bit m_c, m_v, m_z, m_n, m_e, m_u;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsp_mac_unit dut (
    .clk(clk), .rst(rst), .valid(valid), .opcode(opcode),
    .op_a(op_a), .op_b(op_b), .acc_sel(acc_sel),
    .prod(prod), .acc_a(acc_a), .acc_b(acc_b),
    .flag_c(flag_c), .flag_v(flag_v), .flag_z(flag_z),
    .flag_n(flag_n), .flag_e(flag_e), .flag_u(flag_u)
  );

  function automatic longint sx40(input longint x);
    return ((x >> 39) & 1) != 0 ? (x | ~M40) : (x & M40);
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string prod_tag(input int op);
    case (op)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R9";
      default: return "R2";
    endcase
  endfunction

  function automatic string acc_tag(input int op, input bit chosen);
    if (op >= 6) return "R2";
    if (!chosen) return "R12";
    case (op)
      3: return "R6";
      4: return "R7";
      5: return "R9";
      default: return "R3";
    endcase
  endfunction

  function automatic string cv_tag(input int op);
    if (op <= 2) return "R13";
    if (op == 3) return "R6";
    if (op <= 5) return "R10";
    return "R2";
  endfunction

  function automatic string zneu_tag(input int op);
    if (op <= 2) return "R13";
    if (op <= 5) return "R11";
    return "R2";
  endfunction

  // Reference model: one accepted operation
  task automatic model_op(input int op, input logic [15:0] a, input logic [15:0] b,
                          input bit sel);
    longint p, d, s, sum, r, top, lo;
    p = longint'($signed(a)) * longint'($signed(b));
    case (op)
      0: m_prod = p & M40;
      1: m_prod = (sx40(m_prod) + p) & M40;
      2: m_prod = (sx40(m_prod) - p) & M40;
      3, 4, 5: begin
        d = m_prod;
        if (op == 3) s = 0;
        else if (op == 5) s = m_acc[sel];
        else begin
          lo = d & 64'hFFFF;
          if (lo != 64'h8000) s = 64'h8000;
          else s = (((d >> 16) & 1) != 0) ? 64'h8000 : 0;
        end
        sum = d + s;
        r = sum & M40;
        if (op == 4) r = r & ~64'hFFFF;
        m_c = (op != 3) && (((sum >> 40) & 1) != 0);
        m_v = (op != 3) && (((d >> 39) & 1) == ((s >> 39) & 1)) &&
              (((sum >> 39) & 1) != ((d >> 39) & 1));
        m_z = (r == 0);
        m_n = ((r >> 39) & 1) != 0;
        top = (r >> 31) & 64'h1FF;
        m_e = (top != 0) && (top != 64'h1FF);
        m_u = ((r >> 31) & 1) == ((r >> 30) & 1);
        m_acc[sel] = r;
        m_prod = p & M40;
      end
      default: ;
    endcase
  endtask

  task automatic compare_all(input int op, input bit v, input bit sel);
    int eop;
    eop = v ? op : 7;
    chk(prod_tag(eop), longint'(prod), m_prod);
    chk(acc_tag(eop, sel == 1'b0), longint'(acc_a), m_acc[0]);
    chk(acc_tag(eop, sel == 1'b1), longint'(acc_b), m_acc[1]);
    chk(cv_tag(eop), longint'({flag_c, flag_v}), longint'({m_c, m_v}));
    chk(zneu_tag(eop), longint'({flag_z, flag_n, flag_e, flag_u}),
        longint'({m_z, m_n, m_e, m_u}));
  endtask

  task automatic step(input int op, input logic [15:0] a, input logic [15:0] b,
                      input bit sel, input bit v);
    @(negedge clk);
    valid = v; opcode = 3'(op); op_a = a; op_b = b; acc_sel = sel;
    @(posedge clk);
    #1;
    if (v) model_op(op, a, b, sel);
    compare_all(op, v, sel);
  endtask

  task automatic reset_model();
    m_prod = 0; m_acc[0] = 0; m_acc[1] = 0;
    {m_c, m_v, m_z, m_n, m_e, m_u} = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; valid = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    reset_model();
    chk("R1", longint'(prod), 0);
    chk("R1", longint'(acc_a), 0);
    chk("R1", longint'(acc_b), 0);
    chk("R1", longint'({flag_c, flag_v, flag_z, flag_n, flag_e, flag_u}), 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  logic [15:0] vals [8];

  initial begin
    vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'hFFFF; vals[3] = 16'h7FFF;
    vals[4] = 16'h8000; vals[5] = 16'h1234; vals[6] = 16'hC001; vals[7] = 16'h0100;
    reset_model();
    do_reset();

    // Sweep: every opcode, operand pair and target accumulator
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          for (int s = 0; s < 2; s++)
            step(op, vals[i], vals[(i + j + op) % 8], s[0], 1'b1);

    // R2: strobe low, any opcode
    for (int k = 0; k < 64; k++)
      step(k % 8, vals[k % 8], vals[(k * 3) % 8], k[3], 1'b0);

    // R8: exact-half ties; R7: non-tie case
    step(0, 16'd6, 16'd16384, 1'b0, 1'b1);          // prod = 0x18000
    step(4, 16'd0, 16'd0, 1'b0, 1'b1);
    chk("R8", longint'(acc_a), 64'h20000);
    step(0, 16'd2, 16'd16384, 1'b0, 1'b1);          // prod = 0x08000
    step(4, 16'd0, 16'd0, 1'b1, 1'b1);
    chk("R8", longint'(acc_b), 0);
    chk("R11", longint'(flag_z), 1);
    step(0, 16'd5, 16'd19661, 1'b0, 1'b1);          // prod = 0x18001
    step(4, 16'd0, 16'd0, 1'b0, 1'b1);
    chk("R7", longint'(acc_a), 64'h20000);

    // R10: accumulate toward the 40-bit limit to provoke carry and overflow
    do_reset();
    for (int k = 0; k < 560; k++)
      step(k < 540 ? 1 : 5, 16'h8000, 16'h8000, 1'b0, 1'b1);
    for (int k = 0; k < 40; k++)
      step(5, 16'h8000, 16'h8001, k[0], 1'b1);

    // R1: reset in mid-run
    do_reset();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule